// File: doc/BRIEF.md
# Byte-Wide Static RAM on a Shared Processor Bus

This block is a clocked model of a static RAM that hangs on a shared microprocessor bus. The bus master presents an address, write data and three active-low strobes: select, output enable and write enable. The block turns the strobes into one of five operating modes. It stores a word only in write mode. It puts a word on the read-data lines only in read mode, and only once a programmed access time has passed.

The tri-state data pin is modelled as a data output plus a drive flag. While the flag is low, a bus fabric outside the block is free to let another device use the wires, and the data output is held at zero. The access time is a count of clock cycles. It starts again whenever a read begins or the address moves during a read. The number of words, the word width and the access time are parameters, with defaults of 2048 words of 8 bits and 3 cycles.

Top module: `sram_bus_model`

## Requirements
- R1: While `sel_n` is high, `mode` is 0 (disabled), `bus_drive` is low, `rd_data` is zero and no word is stored, whatever `oe_n` and `we_n` are.
- R2: With `sel_n` low, `oe_n` low and `we_n` high, `mode` is 1 (read); once the access time has elapsed, `bus_drive` is high and `rd_data` equals the word stored at `addr`.
- R3: With `sel_n` low, `oe_n` high and `we_n` low, `mode` is 2 (write), and `wr_data` is stored at `addr` on each rising clock edge while that holds.
- R4: With `sel_n` low and both `oe_n` and `we_n` high, `mode` is 3 (wait), the bus is left undriven and stored words are unchanged.
- R5: With `sel_n` low and both `oe_n` and `we_n` low, `mode` is 4 (illegal), `bad_combo` is high, the bus is undriven and no word is stored.
- R6: `bus_drive` rises on the ACCESS_CYC-th rising edge after read mode begins, counting the first edge on which read mode is present, and stays high while the read and the address are held.
- R7: A change of `addr` during a read drops `bus_drive` at once, without waiting for a clock edge, and restarts the access count from the new address.
- R8: While `rst_n` is low and right after it is released, `bus_drive` is low, and a read then needs the full access time.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW = log2(WORDS) | Word address |
| sel_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wr_data | input | WIDTH | Data presented by the bus for a write |
| rd_data | output | WIDTH | Read word, zero when not driving |
| bus_drive | output | 1 | High when the block owns the data bus |
| mode | output | 3 | 0 disabled, 1 read, 2 write, 3 wait, 4 illegal |
| bad_combo | output | 1 | High in the illegal strobe combination |

## Verification
The mode code, the illegal flag and the drop of the drive flag depend only on the present inputs. The bench reads them 2 ns after the falling edge on which it changed the strobes, with no clock edge between. A stored word can be read back from the edge after the write. A read's data is due on the ACCESS_CYC-th rising edge after the strobes enter read mode. The bench checks that the drive flag is still low after each of the earlier edges and high after that one. A scoreboard pops the expected word when the drive flag rises and compares it. It also checks that a word survives the disabled, wait and illegal modes.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;
  typedef enum logic [2:0] {
    MD_OFF  = 3'd0,
    MD_READ = 3'd1,
    MD_WRT  = 3'd2,
    MD_HOLD = 3'd3,
    MD_BAD  = 3'd4
  } bus_mode_t;
endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_bus_pkg::*;
(
  input  logic      sel_n,
  input  logic      oe_n,
  input  logic      we_n,
  output bus_mode_t mode
);
  always_comb begin
    if (sel_n)            mode = MD_OFF;
    else if (!oe_n && we_n) mode = MD_READ;
    else if (oe_n && !we_n) mode = MD_WRT;
    else if (oe_n && we_n)  mode = MD_HOLD;
    else                  mode = MD_BAD;
  end
endmodule

// File: rtl/sram_access_timer.sv
module sram_access_timer #(
  parameter int ACCESS_CYC = 3,
  parameter int AW         = 11,
  localparam int CW        = $clog2(ACCESS_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] addr,
  output logic          ready
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rd_q;
  logic [AW-1:0] addr_q;
  logic          restart;

  assign restart = !rd_q || (addr != addr_q);

  always_comb begin
    cnt_d = cnt_q;
    if (!rd_req)                           cnt_d = '0;
    else if (restart)                      cnt_d = CW'(1);
    else if (cnt_q != CW'(ACCESS_CYC))     cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      rd_q   <= rd_req;
      addr_q <= addr;
    end
  end

  assign ready = rd_req && !restart && (cnt_q == CW'(ACCESS_CYC));
endmodule

// File: rtl/sram_cell_array.sv
module sram_cell_array #(
  parameter int WORDS = 2048,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/sram_bus_model.sv
module sram_bus_model
  import sram_bus_pkg::*;
#(
  parameter int WORDS      = 2048,
  parameter int WIDTH      = 8,
  parameter int ACCESS_CYC = 3,
  localparam int AW        = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             sel_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             bus_drive,
  output logic [2:0]       mode,
  output logic             bad_combo
);
  bus_mode_t        cur_mode;
  logic             ready;
  logic [WIDTH-1:0] cell_word;

  sram_mode_decode u_dec (
    .sel_n (sel_n),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .mode  (cur_mode)
  );

  sram_access_timer #(.ACCESS_CYC(ACCESS_CYC), .AW(AW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_req (cur_mode == MD_READ),
    .addr   (addr),
    .ready  (ready)
  );

  sram_cell_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u_mem (
    .clk   (clk),
    .wr_en (cur_mode == MD_WRT),
    .addr  (addr),
    .wdata (wr_data),
    .rdata (cell_word)
  );

  assign bus_drive = ready;
  assign rd_data   = ready ? cell_word : '0;
  assign mode      = cur_mode;
  assign bad_combo = (cur_mode == MD_BAD);
endmodule

// File: rtl/sram_bus_checks.sv
module sram_bus_checks #(
  parameter int AW    = 11,
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic             sel_n,
  input logic             oe_n,
  input logic             we_n,
  input logic [WIDTH-1:0] rd_data,
  input logic             bus_drive,
  input logic [2:0]       mode,
  input logic             bad_combo
);
  p_quiet_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> (!bus_drive && mode == 3'd0 && rd_data == '0));

  p_drive_only_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (!sel_n && !oe_n && we_n && mode == 3'd1));

  p_write_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && oe_n && !we_n) |-> (mode == 3'd2 && !bus_drive));

  p_wait_undriven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && oe_n && we_n) |-> (mode == 3'd3 && !bus_drive));

  p_bad_flagged_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !oe_n && !we_n) |-> (bad_combo && !bus_drive && mode == 3'd4));

  p_rise_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drive) |-> $past(mode == 3'd1));

  p_addr_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> $stable(addr));
endmodule

bind sram_bus_model sram_bus_checks #(.AW(AW), .WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .sel_n     (sel_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .rd_data   (rd_data),
  .bus_drive (bus_drive),
  .mode      (mode),
  .bad_combo (bad_combo)
);

// File: tb/sram_bus_model_test.sv
`timescale 1ns/100ps
module sram_bus_model_test;
  localparam int WORDS = 2048;
  localparam int WIDTH = 8;
  localparam int ACC   = 3;
  localparam int AW    = $clog2(WORDS);

  logic             clk = 1'b0;
  logic             rst_n;
  logic [AW-1:0]    addr;
  logic             sel_n, oe_n, we_n;
  logic [WIDTH-1:0] wr_data;
  logic [WIDTH-1:0] rd_data;
  logic             bus_drive;
  logic [2:0]       mode;
  logic             bad_combo;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] expq [$];
  logic drv_prev = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  sram_bus_model #(.WORDS(WORDS), .WIDTH(WIDTH), .ACCESS_CYC(ACC)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .oe_n(oe_n),
    .we_n(we_n), .wr_data(wr_data), .rd_data(rd_data), .bus_drive(bus_drive),
    .mode(mode), .bad_combo(bad_combo)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops an expected word each time the block takes the bus
  always @(negedge clk) begin
    #2;
    if (bus_drive && !drv_prev) begin
      if (expq.size() == 0) chk(1'b0, "R2 unexpected drive", rd_data, 0);
      else begin
        logic [WIDTH-1:0] e;
        e = expq.pop_front();
        chk(rd_data == e, "R2 read word", rd_data, e);
      end
    end
    drv_prev = bus_drive;
  end

  task automatic set_bus(input logic s, input logic o, input logic w,
                         input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
    sel_n = s; oe_n = o; we_n = w; addr = a; wr_data = d;
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
    @(negedge clk);
    set_bus(1'b0, 1'b1, 1'b0, a, d);
    #2 chk(mode == 3'd2 && !bus_drive, "R3 write code", mode, 2);
    @(negedge clk);
    set_bus(1'b1, 1'b1, 1'b1, a, d);
  endtask

  // driver: starts a read, pushes the expected word, checks the access time
  task automatic read_word(input logic [AW-1:0] a, input logic [WIDTH-1:0] e);
    @(negedge clk);
    expq.push_back(e);
    set_bus(1'b0, 1'b0, 1'b1, a, '0);
    #2 chk(mode == 3'd1 && !bus_drive, "R6 no drive at start", bus_drive, 0);
    for (int k = 1; k <= ACC; k++) begin
      @(negedge clk);
      #2;
      if (k < ACC) chk(!bus_drive, "R6 early drive", bus_drive, 0);
      else         chk(bus_drive && rd_data == e, "R6 drive on time", rd_data, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    set_bus(1'b1, 1'b1, 1'b1, '0, '0);
    repeat (3) @(negedge clk);
    #2 chk(!bus_drive && rd_data == '0 && mode == 3'd0, "R8 reset state", bus_drive, 0);
    rst_n = 1'b1;

    write_word(11'd5, 8'hA5);
    write_word(11'd2047, 8'h3C);
    write_word(11'd0, 8'h11);

    read_word(11'd5, 8'hA5);
    // held read stays valid (R6)
    @(negedge clk); #2 chk(bus_drive && rd_data == 8'hA5, "R6 held", rd_data, 8'hA5);

    // address change mid-read: R7
    @(negedge clk);
    expq.push_back(8'h3C);
    addr = 11'd2047;
    #2 chk(!bus_drive && rd_data == '0, "R7 immediate drop", bus_drive, 0);
    for (int k = 1; k <= ACC; k++) begin
      @(negedge clk); #2;
      if (k < ACC) chk(!bus_drive, "R7 restart count", bus_drive, 0);
      else         chk(bus_drive && rd_data == 8'h3C, "R7 new word", rd_data, 8'h3C);
    end

    // illegal strobes: R5
    @(negedge clk);
    set_bus(1'b0, 1'b0, 1'b0, 11'd5, 8'hFF);
    #2 chk(bad_combo && mode == 3'd4 && !bus_drive, "R5 illegal flag", mode, 4);
    repeat (2) @(negedge clk);
    #2 chk(!bus_drive && rd_data == '0, "R5 no drive", bus_drive, 0);
    read_word(11'd5, 8'hA5);   // R5 no write happened

    // wait state: R4
    @(negedge clk);
    set_bus(1'b0, 1'b1, 1'b1, 11'd2047, 8'h00);
    #2 chk(mode == 3'd3 && !bus_drive, "R4 wait code", mode, 3);
    repeat (3) @(negedge clk);
    #2 chk(!bus_drive && rd_data == '0, "R4 undriven", bus_drive, 0);
    read_word(11'd2047, 8'h3C);

    // deselected with strobes low: R1
    @(negedge clk);
    set_bus(1'b1, 1'b0, 1'b0, 11'd0, 8'h77);
    #2 chk(mode == 3'd0 && !bus_drive && rd_data == '0, "R1 disabled", mode, 0);
    repeat (3) @(negedge clk);
    #2 chk(!bus_drive, "R1 no drive", bus_drive, 0);
    read_word(11'd0, 8'h11);

    // overwrite then read: R3
    write_word(11'd0, 8'h5A);
    read_word(11'd0, 8'h5A);

    // reset in the middle of a read: R8
    @(negedge clk);
    set_bus(1'b0, 1'b0, 1'b1, 11'd5, '0);
    expq.push_back(8'hA5);
    @(negedge clk);
    rst_n = 1'b0;
    #2 chk(!bus_drive, "R8 reset drops drive", bus_drive, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 1; k <= ACC; k++) begin
      @(negedge clk); #2;
      if (k < ACC) chk(!bus_drive, "R8 full access after reset", bus_drive, 0);
      else         chk(bus_drive && rd_data == 8'hA5, "R8 read after reset", rd_data, 8'hA5);
    end

    @(negedge clk);
    set_bus(1'b1, 1'b1, 1'b1, '0, '0);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R2 scoreboard drained", expq.size(), 0);
    finish_run();
  end
endmodule